// File: doc/BRIEF.md
# Parallel Framed Byte Receiver

This block takes bytes from an asynchronous sender over an 8-bit parallel bus. The sender places a byte on the bus and raises a strobe. It also holds a frame-start line high while it sends the first byte of a frame. The receiver passes both control lines through synchronizers and detects the rising edge of the strobe. One cycle after that edge it samples the data, once the bus has settled, and writes the byte into an eight-entry register bank. It then answers with an acknowledge pulse of fixed length, which tells the sender that it may present the next byte.

The frame-start level resynchronizes the write index. A sender that lost its place can restart at slot 0 with its next frame-start byte. Once all eight slots of a frame are written, the block raises a one-cycle frame-complete pulse. It then refuses further bytes until a new frame starts. A combinational read port gives access to any stored byte at any time.

Top module: `pbus_frame_rx`

## Requirements
- R1: A byte is captured after a synchronized rising edge of `bus_stb`. It is stored unchanged as an 8-bit value, and the bus is sampled one clock after the synchronized edge.
- R2: If `bus_sof` is high when a byte is captured, that byte goes to slot 0, whatever the current write index is.
- R3: Each stored byte goes to the current write index, and the index then advances by one. Consecutive bytes of a frame therefore occupy slots 0, 1, 2, and so on.
- R4: Every stored byte produces exactly one pulse on `ack_out`, which stays high for exactly ACK_CYCLES (default 12) clock cycles. The pulse starts on the clock after the write.
- R5: A strobe rising edge that is detected while `ack_out` is high is ignored. Nothing is stored, no new acknowledge pulse is produced, and the write index does not change.
- R6: When slot 7 (the last slot, DEPTH-1) is written, `frame_done` is high for exactly one clock cycle.
- R7: After slot 7 has been written, strobes with `bus_sof` low are ignored, with no store and no acknowledge. A strobe with `bus_sof` high stores its byte in slot 0 and starts a new frame.
- R8: `rd_data` shows the slot selected by `rd_addr` combinationally. Reset clears all slots to zero and drives `ack_out` and `frame_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_data | input | 8 | Parallel data from the sender |
| bus_stb | input | 1 | Sender strobe; a rising edge announces a byte |
| bus_sof | input | 1 | Frame-start level, high during the first byte of a frame |
| ack_out | output | 1 | Acknowledge pulse back to the sender |
| rd_addr | input | 3 | Read slot select |
| rd_data | output | 8 | Stored byte at `rd_addr` |
| frame_done | output | 1 | One-cycle pulse when the last slot is written |

## Verification
A full frame of data values (all-ones, all-zeros, alternating and single-bit patterns) shows that stored bytes are unchanged and that slots advance in order. A frame-start byte sent in the middle of a frame shows that resynchronization overrides the index. A second strobe edge raised inside an acknowledge pulse, carrying a different data value, separates a receiver that drops it from one that stores it or re-acknowledges. Bytes sent after a complete frame, first without and then with frame-start, show the hold-until-restart behaviour and the single frame-complete pulse.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  // Slot a capture lands in: frame-start forces slot 0, else the running index.
  function automatic int unsigned target_slot(input logic sof, input int unsigned idx);
    return sof ? 0 : idx;
  endfunction

  // A capture is stored only while the target slot is inside the bank.
  function automatic logic slot_in_bank(input int unsigned slot, input int unsigned depth);
    return slot < depth;
  endfunction
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pbus_ack_timer.sv
module pbus_ack_timer #(
  parameter int CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/pbus_bank.sv
module pbus_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        slot_q[g] <= '0;
      else if (we && waddr == AW'(g))    slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/pbus_frame_rx.sv
module pbus_frame_rx #(
  parameter int DW          = 8,
  parameter int DEPTH       = 8,
  parameter int ACK_CYCLES  = 12,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int IW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_stb,
  input  logic          bus_sof,
  output logic          ack_out,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          frame_done
);
  import pbus_pkg::*;

  // Named internal events, observed by the bound checker.
  logic          stb_s, sof_s, stb_d;
  logic          stb_rise;
  logic          cap_pend;
  logic          wr_evt;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] eff_idx;
  logic [AW-1:0] wr_slot;
  logic          ack_busy;

  pbus_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d(bus_stb), .q(stb_s));

  pbus_sync #(.STAGES(SYNC_STAGES)) u_sync_sof (
    .clk(clk), .rst_n(rst_n), .d(bus_sof), .q(sof_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_d <= 1'b0;
    else        stb_d <= stb_s;
  end

  assign stb_rise = stb_s & ~stb_d;

  // Edge seen while acknowledging is dropped; otherwise sample one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_pend <= 1'b0;
    else        cap_pend <= stb_rise & ~ack_busy;
  end

  assign eff_idx = IW'(target_slot(sof_s, int'(wr_idx)));
  assign wr_evt  = cap_pend & slot_in_bank(int'(eff_idx), DEPTH);
  assign wr_slot = eff_idx[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_idx <= '0;
    else if (wr_evt) wr_idx <= eff_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_done <= 1'b0;
    else        frame_done <= wr_evt && (eff_idx == IW'(DEPTH - 1));
  end

  pbus_ack_timer #(.CYCLES(ACK_CYCLES)) u_ack (
    .clk(clk), .rst_n(rst_n), .start(wr_evt), .busy(ack_busy));

  assign ack_out = ack_busy;

  pbus_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(wr_evt), .waddr(wr_slot), .wdata(bus_data),
    .raddr(rd_addr), .rdata(rd_data));
endmodule

// File: rtl/pbus_frame_rx_chk.sv
module pbus_frame_rx_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_evt,
  input logic [AW-1:0] wr_slot,
  input logic          sof_s,
  input logic          ack_out,
  input logic          frame_done
);
  // R4
  ack_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ack_out);

  // R5
  no_write_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> !wr_evt);

  // R2
  sof_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && sof_s) |-> (wr_slot == '0));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(wr_evt) && $past(wr_slot) == AW'(DEPTH - 1)));

  // R6
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind pbus_frame_rx pbus_frame_rx_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_slot(wr_slot),
  .sof_s(sof_s), .ack_out(ack_out), .frame_done(frame_done));

// File: tb/pbus_frame_rx_tb.sv
module pbus_frame_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_LEN    = 12;
  localparam int NVEC       = 12;
  // Each vector: {sof, expected slot[2:0], data[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 8'hA5}, {1'b0, 3'd1, 8'h3C}, {1'b0, 3'd2, 8'hFF},
    {1'b0, 3'd3, 8'h00}, {1'b0, 3'd4, 8'h81}, {1'b0, 3'd5, 8'h7E},
    {1'b0, 3'd6, 8'h55}, {1'b0, 3'd7, 8'hAA}, {1'b1, 3'd0, 8'h12},
    {1'b0, 3'd1, 8'h34}, {1'b1, 3'd0, 8'h56}, {1'b0, 3'd1, 8'h78}};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic       bus_stb = 1'b0;
  logic       bus_sof = 1'b0;
  logic       ack_out;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       frame_done;

  int checks = 0;
  int fails  = 0;
  int fd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_stb(bus_stb),
    .bus_sof(bus_sof), .ack_out(ack_out), .rd_addr(rd_addr),
    .rd_data(rd_data), .frame_done(frame_done));

  always @(negedge clk) if (rst_n && frame_done) fd_cnt++;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_slot(input int slot, output logic [7:0] val);
    rd_addr = 3'(slot);
    #1 val = rd_data;
  endtask

  // Present a byte, wait for the acknowledge, measure its width, release strobe.
  task automatic send(input logic sof, input logic [7:0] d, output logic got, output int width);
    @(negedge clk);
    bus_data = d; bus_sof = sof; bus_stb = 1'b1;
    got = 1'b0; width = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ack_out) begin got = 1'b1; break; end
    end
    if (got) while (ack_out && width < 40) begin width++; @(negedge clk); end
    bus_stb = 1'b0; bus_sof = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic got; int w; logic [7:0] v; int fd0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(ack_out == 1'b0, "R8 ack reset", ack_out, 0);
    check(frame_done == 1'b0, "R8 done reset", frame_done, 0);
    for (int s = 0; s < 8; s++) begin
      read_slot(s, v);
      check(v == 8'h00, "R8 slot reset", v, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4
    for (int k = 0; k < NVEC; k++) begin
      send(VEC[k][11], VEC[k][7:0], got, w);
      check(got, "R4 ack seen", got, 1);
      check(w == ACK_LEN, "R4 ack width", w, ACK_LEN);
      read_slot(int'(VEC[k][10:8]), v);
      check(v == VEC[k][7:0], "R1 R2 R3 stored byte", v, VEC[k][7:0]);
    end
    check(fd_cnt == 1, "R6 frame done count", fd_cnt, 1);
    read_slot(7, v);
    check(v == 8'hAA, "R2 slot7 kept after resync", v, 8'hAA);

    // R5: edge inside acknowledge is dropped
    do_reset();
    check(ack_out == 1'b0, "R8 ack after reset", ack_out, 0);
    @(negedge clk);
    bus_data = 8'h61; bus_sof = 1'b1; bus_stb = 1'b1;
    while (!ack_out) @(negedge clk);
    bus_stb = 1'b0; bus_sof = 1'b0;
    repeat (3) @(negedge clk);
    bus_data = 8'hEE; bus_stb = 1'b1;
    while (ack_out) @(negedge clk);
    got = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ack_out) got = 1'b1;
    end
    check(!got, "R5 no second ack", got, 0);
    bus_stb = 1'b0;
    repeat (4) @(negedge clk);
    read_slot(1, v);
    check(v == 8'h00, "R5 ignored byte not stored", v, 0);
    send(1'b0, 8'h62, got, w);
    read_slot(1, v);
    check(v == 8'h62, "R5 index unchanged", v, 8'h62);
    read_slot(2, v);
    check(v == 8'h00, "R5 slot2 untouched", v, 0);

    // R7: hold after full frame, restart on frame-start
    do_reset();
    fd0 = fd_cnt;
    for (int i = 0; i < 8; i++) send(i == 0, 8'(8'h10 + i), got, w);
    check(fd_cnt == fd0 + 1, "R6 one pulse per frame", fd_cnt, fd0 + 1);
    send(1'b0, 8'h99, got, w);
    check(!got, "R7 no ack when full", got, 0);
    read_slot(0, v);
    check(v == 8'h10, "R7 slot0 held", v, 8'h10);
    read_slot(7, v);
    check(v == 8'h17, "R7 slot7 held", v, 8'h17);
    check(fd_cnt == fd0 + 1, "R7 no extra done", fd_cnt, fd0 + 1);
    send(1'b1, 8'h42, got, w);
    check(got, "R7 restart acked", got, 1);
    read_slot(0, v);
    check(v == 8'h42, "R7 restart slot0", v, 8'h42);
    read_slot(1, v);
    check(v == 8'h11, "R7 slot1 kept", v, 8'h11);

    // R8 read port is combinational: no clock edge between address and data
    rd_addr = 3'd3;
    #1 check(rd_data == 8'h13, "R8 comb read", rd_data, 8'h13);
    rd_addr = 3'd6;
    #1 check(rd_data == 8'h16, "R8 comb read", rd_data, 8'h16);

    // R8 reset clears stored bytes
    do_reset();
    read_slot(0, v);
    check(v == 8'h00, "R8 bank cleared", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule